// File: doc/BRIEF.md
# Interrupt Request and In-Service Tracker

This block holds the interrupt bookkeeping of one processor's interrupt controller. It has two 256-entry vector sets. The pending set records vectors that have been raised but not yet taken. The in-service set records vectors that have been taken but not yet retired. Each set is stored as eight 32-bit words. A scanner looks at the words from the top word down and finds the highest vector in each set. That result is held in a register, so the highest pending and highest in-service vectors are always ready for the core with no search in the request path.

A request strobe marks one vector as pending. An accept strobe moves the highest pending vector into service. An end-of-interrupt strobe retires the highest in-service vector. A deliverable flag tells the core whether a pending interrupt outranks the work already in service. The comparison uses the priority class, which is the top four bits of the vector.

Five special interrupt kinds do not go through the pending set: system management, non-maskable, external, init and start-up. Each kind has its own pending flag and its own stored vector. A summary flag reports whether any of these kinds is pending except the external kind.

Top module: `irq_tracker`

## Requirements
- R1: Vector v lives in word v/32 at bit v%32. A request for any vector from 0 to 255 (including the edge vectors 31, 32 and 255) makes that vector visible through the highest-pending output.
- R2: The highest-pending and highest-in-service outputs are registered. They report the highest vector in their set as it stands after the rising edge on which a change took effect, and they are valid right after that same edge.
- R3: An empty set reports 0 on its highest-vector output and drives its nonempty flag (`pend_any` / `svc_any`) low. A set that holds only vector 0 also reports 0, but its nonempty flag is high.
- R4: When `accept` is high and the pending set is not empty, the highest pending vector is removed from the pending set and added to the in-service set at the same edge. When `accept` is high and the pending set is empty, nothing changes.
- R5: When `eoi` is high and the in-service set is not empty, the highest in-service vector is removed from that set. When `eoi` is high and the in-service set is empty, nothing changes.
- R6: Strobes that arrive in the same cycle all take effect. Within a set, clears are applied before sets. So a request for the vector being accepted leaves that vector pending. An accept together with an EOI on the same vector leaves that vector in service.
- R7: `deliverable` is high only when the pending set is not empty and either the in-service set is empty or the pending vector's class (bits 7:4) is strictly greater than the in-service vector's class.
- R8: Special kinds are coded as 0 for system management, 1 for non-maskable, 2 for external, 3 for init and 4 for start-up. A set strobe raises the flag for its kind (bit k of `spc_pend`) and stores its vector in `spc_vecs[8k+7:8k]`. A clear strobe lowers the flag and keeps the stored vector. A set wins over a clear of the same kind in the same cycle. Kind codes 5 to 7 have no effect.
- R9: `unmask_pend` is the OR of the special flags for kinds 0, 1, 3 and 4. A pending external request alone never raises it.
- R10: Reset (active-low, asynchronous) empties both sets, clears every special flag and stored vector, and drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mark `req_vec` as pending |
| req_vec | input | 8 | Vector to mark as pending |
| accept | input | 1 | Move the highest pending vector into service |
| eoi | input | 1 | Retire the highest in-service vector |
| spc_set_valid | input | 1 | Raise a special-kind flag |
| spc_set_kind | input | 3 | Kind code for the set strobe |
| spc_set_vec | input | 8 | Vector stored with the set strobe |
| spc_clr_valid | input | 1 | Lower a special-kind flag |
| spc_clr_kind | input | 3 | Kind code for the clear strobe |
| pend_hi | output | 8 | Highest pending vector |
| pend_any | output | 1 | Pending set is not empty |
| svc_hi | output | 8 | Highest in-service vector |
| svc_any | output | 1 | In-service set is not empty |
| deliverable | output | 1 | A pending vector outranks the in-service class |
| spc_pend | output | 5 | Special-kind pending flags, one bit per kind code |
| spc_vecs | output | 40 | Stored special vectors, 8 bits per kind |
| unmask_pend | output | 1 | Any special kind pending other than external |

## Verification
The collisions that matter are an accept in the same cycle as a request, and an accept in the same cycle as an EOI. In both cases one set receives a clear and a set in a single edge. Directed steps force each collision onto the same vector, because that is where clear-before-set ordering decides the result. A long random phase then raises all three strobes with independent odds. A behavioural model of both sets, comparing outputs on every cycle, checks that every strobe took effect.

// File: rtl/irq_tracker_pkg.sv
package irq_tracker_pkg;

   localparam int KIND_W    = 3;
   localparam int SPC_KINDS = 5;

   typedef enum logic [KIND_W-1:0] {
      SPC_SMM   = 3'd0,
      SPC_NMI   = 3'd1,
      SPC_EXT   = 3'd2,
      SPC_INIT  = 3'd3,
      SPC_START = 3'd4
   } spc_kind_e;

   // Kinds that count toward the summary flag: all except external.
   localparam logic [SPC_KINDS-1:0] UNMASK_SEL =
      ~(SPC_KINDS'(1) << int'(SPC_EXT));

endpackage

// File: rtl/irq_word_scan.sv
module irq_word_scan #(
   parameter  int NUM_WORDS = 8,
   parameter  int WORD_W    = 32,
   localparam int VEC_W     = $clog2(NUM_WORDS * WORD_W),
   localparam int BIT_W     = $clog2(WORD_W)
) (
   input  logic [NUM_WORDS*WORD_W-1:0] words,
   output logic [VEC_W-1:0]            top_vec,
   output logic                        any_set
);

   logic [NUM_WORDS-1:0]       word_nz;
   logic [NUM_WORDS*BIT_W-1:0] word_msb;

   // Per-word reduction and most significant set bit
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] slice;
      logic [BIT_W-1:0]  msb;

      assign slice      = words[w*WORD_W +: WORD_W];
      assign word_nz[w] = |slice;

      always_comb begin
         msb = '0;
         for (int b = 0; b < WORD_W; b++) begin
            if (slice[b]) msb = BIT_W'(b);
         end
      end

      assign word_msb[w*BIT_W +: BIT_W] = msb;
   end

   // Top word first; the first nonzero word decides
   always_comb begin
      top_vec = '0;
      any_set = 1'b0;
      for (int w = NUM_WORDS - 1; w >= 0; w--) begin
         if (!any_set && word_nz[w]) begin
            any_set = 1'b1;
            top_vec = VEC_W'(w * WORD_W) + VEC_W'(word_msb[w*BIT_W +: BIT_W]);
         end
      end
   end

endmodule

// File: rtl/irq_vec_set.sv
module irq_vec_set #(
   parameter  int NUM_VEC   = 256,
   parameter  int WORD_W    = 32,
   localparam int NUM_WORDS = NUM_VEC / WORD_W,
   localparam int VEC_W     = $clog2(NUM_VEC),
   localparam int BIT_W     = $clog2(WORD_W),
   localparam int IDX_W     = VEC_W - BIT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [VEC_W-1:0] set_vec,
   input  logic             clr_en,
   input  logic [VEC_W-1:0] clr_vec,
   output logic [VEC_W-1:0] top_vec,
   output logic             any_set
);

   logic [NUM_VEC-1:0] bits_q;
   logic [NUM_VEC-1:0] bits_d;
   logic [VEC_W-1:0]   nxt_top;
   logic               nxt_any;

   // Word update: clear first, then set, so a set wins on the same bit
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic              set_hit;
      logic              clr_hit;
      logic [WORD_W-1:0] set_mask;
      logic [WORD_W-1:0] clr_mask;

      assign set_hit  = set_en && (set_vec[VEC_W-1:BIT_W] == IDX_W'(w));
      assign clr_hit  = clr_en && (clr_vec[VEC_W-1:BIT_W] == IDX_W'(w));
      assign set_mask = set_hit ? (WORD_W'(1) << set_vec[BIT_W-1:0]) : '0;
      assign clr_mask = clr_hit ? (WORD_W'(1) << clr_vec[BIT_W-1:0]) : '0;

      assign bits_d[w*WORD_W +: WORD_W] =
         (bits_q[w*WORD_W +: WORD_W] & ~clr_mask) | set_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q <= '0;
      else        bits_q <= bits_d;
   end

   irq_word_scan #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W)
   ) u_scan (
      .words   (bits_d),
      .top_vec (nxt_top),
      .any_set (nxt_any)
   );

   // Cached result, consistent with bits_q after every edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_vec <= '0;
         any_set <= 1'b0;
      end else begin
         top_vec <= nxt_top;
         any_set <= nxt_any;
      end
   end

endmodule

// File: rtl/irq_special.sv
module irq_special
   import irq_tracker_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      set_valid,
   input  logic [KIND_W-1:0]         set_kind,
   input  logic [VEC_W-1:0]          set_vec,
   input  logic                      clr_valid,
   input  logic [KIND_W-1:0]         clr_kind,
   output logic [SPC_KINDS-1:0]      pend,
   output logic [SPC_KINDS*VEC_W-1:0] vecs
);

   for (genvar k = 0; k < SPC_KINDS; k++) begin : g_kind
      logic             flag_q;
      logic [VEC_W-1:0] vec_q;
      logic             set_hit;
      logic             clr_hit;

      assign set_hit = set_valid && (set_kind == KIND_W'(k));
      assign clr_hit = clr_valid && (clr_kind == KIND_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
            vec_q  <= '0;
         end else if (set_hit) begin
            flag_q <= 1'b1;
            vec_q  <= set_vec;
         end else if (clr_hit) begin
            flag_q <= 1'b0;
         end
      end

      assign pend[k]                 = flag_q;
      assign vecs[k*VEC_W +: VEC_W]  = vec_q;
   end

endmodule

// File: rtl/irq_tracker.sv
module irq_tracker
   import irq_tracker_pkg::*;
#(
   parameter  int NUM_VEC = 256,
   parameter  int WORD_W  = 32,
   parameter  int CLASS_W = 4,
   localparam int VEC_W   = $clog2(NUM_VEC)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [VEC_W-1:0]            req_vec,
   input  logic                        accept,
   input  logic                        eoi,
   input  logic                        spc_set_valid,
   input  logic [KIND_W-1:0]           spc_set_kind,
   input  logic [VEC_W-1:0]            spc_set_vec,
   input  logic                        spc_clr_valid,
   input  logic [KIND_W-1:0]           spc_clr_kind,
   output logic [VEC_W-1:0]            pend_hi,
   output logic                        pend_any,
   output logic [VEC_W-1:0]            svc_hi,
   output logic                        svc_any,
   output logic                        deliverable,
   output logic [SPC_KINDS-1:0]        spc_pend,
   output logic [SPC_KINDS*VEC_W-1:0]  spc_vecs,
   output logic                        unmask_pend
);

   // Elaboration-time parameter checks
   if (NUM_VEC % WORD_W != 0 || NUM_VEC <= WORD_W) begin : g_bad_split
      $error("NUM_VEC must be a multiple of WORD_W and larger than it");
   end
   if ((1 << VEC_W) != NUM_VEC || (1 << $clog2(WORD_W)) != WORD_W) begin : g_bad_pow2
      $error("NUM_VEC and WORD_W must be powers of two");
   end
   if (CLASS_W < 1 || CLASS_W > VEC_W) begin : g_bad_class
      $error("CLASS_W must lie between 1 and the vector width");
   end

   logic do_accept;
   logic do_eoi;

   assign do_accept = accept && pend_any;
   assign do_eoi    = eoi && svc_any;

   // Pending set: request sets, accept clears
   irq_vec_set #(
      .NUM_VEC (NUM_VEC),
      .WORD_W  (WORD_W)
   ) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (req_valid),
      .set_vec (req_vec),
      .clr_en  (do_accept),
      .clr_vec (pend_hi),
      .top_vec (pend_hi),
      .any_set (pend_any)
   );

   // In-service set: accept sets, end-of-interrupt clears
   irq_vec_set #(
      .NUM_VEC (NUM_VEC),
      .WORD_W  (WORD_W)
   ) u_svc (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (do_accept),
      .set_vec (pend_hi),
      .clr_en  (do_eoi),
      .clr_vec (svc_hi),
      .top_vec (svc_hi),
      .any_set (svc_any)
   );

   irq_special #(
      .VEC_W (VEC_W)
   ) u_spc (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_valid (spc_set_valid),
      .set_kind  (spc_set_kind),
      .set_vec   (spc_set_vec),
      .clr_valid (spc_clr_valid),
      .clr_kind  (spc_clr_kind),
      .pend      (spc_pend),
      .vecs      (spc_vecs)
   );

   assign deliverable = pend_any &&
      (!svc_any || (pend_hi[VEC_W-1 -: CLASS_W] > svc_hi[VEC_W-1 -: CLASS_W]));

   assign unmask_pend = |(spc_pend & UNMASK_SEL);

endmodule

// File: rtl/irq_tracker_chk.sv
module irq_tracker_chk
   import irq_tracker_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        req_valid,
   input logic [VEC_W-1:0]            req_vec,
   input logic                        accept,
   input logic                        eoi,
   input logic                        spc_set_valid,
   input logic [KIND_W-1:0]           spc_set_kind,
   input logic [SPC_KINDS-1:0]        spc_pend,
   input logic [VEC_W-1:0]            pend_hi,
   input logic                        pend_any,
   input logic [VEC_W-1:0]            svc_hi,
   input logic                        svc_any,
   input logic                        deliverable,
   input logic                        unmask_pend
);

   // R2
   req_raises_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> pend_any && (pend_hi >= $past(req_vec)));

   // R3
   empty_pend_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_any |-> (pend_hi == '0));

   // R3
   empty_svc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !svc_any |-> (svc_hi == '0));

   // R4
   accept_fills_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pend_any) |=> svc_any && (svc_hi >= $past(pend_hi)));

   // R5
   eoi_lowers_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && svc_any && !accept) |=> (!svc_any || (svc_hi < $past(svc_hi))));

   // R7
   deliver_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deliverable |-> pend_any);

   // R8
   spc_set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spc_set_valid && (spc_set_kind < KIND_W'(SPC_KINDS))) |=>
         |(spc_pend & (SPC_KINDS'(1) << $past(spc_set_kind))));

   // R9
   ext_alone_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spc_pend == (SPC_KINDS'(1) << int'(SPC_EXT))) |-> !unmask_pend);

   // R9
   no_spc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spc_pend == '0) |-> !unmask_pend);

endmodule

bind irq_tracker irq_tracker_chk #(.VEC_W(VEC_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_vec       (req_vec),
   .accept        (accept),
   .eoi           (eoi),
   .spc_set_valid (spc_set_valid),
   .spc_set_kind  (spc_set_kind),
   .spc_pend      (spc_pend),
   .pend_hi       (pend_hi),
   .pend_any      (pend_any),
   .svc_hi        (svc_hi),
   .svc_any       (svc_any),
   .deliverable   (deliverable),
   .unmask_pend   (unmask_pend)
);

// File: tb/irq_tracker_bench.sv
module irq_tracker_bench;

   localparam int NV = 256;
   localparam int NK = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vec = '0;
   logic        accept = 1'b0;
   logic        eoi = 1'b0;
   logic        spc_set_valid = 1'b0;
   logic [2:0]  spc_set_kind = '0;
   logic [7:0]  spc_set_vec = '0;
   logic        spc_clr_valid = 1'b0;
   logic [2:0]  spc_clr_kind = '0;
   logic [7:0]  pend_hi;
   logic        pend_any;
   logic [7:0]  svc_hi;
   logic        svc_any;
   logic        deliverable;
   logic [4:0]  spc_pend;
   logic [39:0] spc_vecs;
   logic        unmask_pend;

   always #5 clk = ~clk;

   irq_tracker u_irq_tracker (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_vec (req_vec),
      .accept (accept), .eoi (eoi),
      .spc_set_valid (spc_set_valid), .spc_set_kind (spc_set_kind),
      .spc_set_vec (spc_set_vec), .spc_clr_valid (spc_clr_valid),
      .spc_clr_kind (spc_clr_kind),
      .pend_hi (pend_hi), .pend_any (pend_any),
      .svc_hi (svc_hi), .svc_any (svc_any),
      .deliverable (deliverable), .spc_pend (spc_pend),
      .spc_vecs (spc_vecs), .unmask_pend (unmask_pend)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Behavioural reference state
   bit       m_irr [NV];
   bit       m_isr [NV];
   bit       m_sp  [NK];
   int       m_sv  [NK];
   int       hp_m, hs_m;

   function automatic int top_of(input bit a [NV]);
      for (int v = NV - 1; v >= 0; v--) if (a[v]) return v;
      return -1;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int v = 0; v < NV; v++) begin m_irr[v] = 0; m_isr[v] = 0; end
         for (int k = 0; k < NK; k++) begin m_sp[k] = 0; m_sv[k] = 0; end
      end else begin
         hp_m = top_of(m_irr);
         hs_m = top_of(m_isr);
         if (eoi && hs_m >= 0) m_isr[hs_m] = 0;
         if (accept && hp_m >= 0) begin m_irr[hp_m] = 0; m_isr[hp_m] = 1; end
         if (req_valid) m_irr[req_vec] = 1;
         if (spc_clr_valid && spc_clr_kind < 5) m_sp[spc_clr_kind] = 0;
         if (spc_set_valid && spc_set_kind < 5) begin
            m_sp[spc_set_kind] = 1;
            m_sv[spc_set_kind] = int'(spc_set_vec);
         end
      end
   end

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         int hp, hs, dl;
         hp = top_of(m_irr);
         hs = top_of(m_isr);
         chk("R2 pend_hi", int'(pend_hi), (hp < 0) ? 0 : hp);
         chk("R3 pend_any", int'(pend_any), (hp >= 0) ? 1 : 0);
         chk("R2 svc_hi", int'(svc_hi), (hs < 0) ? 0 : hs);
         chk("R3 svc_any", int'(svc_any), (hs >= 0) ? 1 : 0);
         dl = (hp >= 0 && (hs < 0 || (hp / 16) > (hs / 16))) ? 1 : 0;
         chk("R7 deliverable", int'(deliverable), dl);
         for (int k = 0; k < NK; k++) begin
            chk("R8 spc_pend", int'(spc_pend[k]), int'(m_sp[k]));
            chk("R8 spc_vec", int'(spc_vecs[k*8 +: 8]), m_sv[k]);
         end
         chk("R9 unmask_pend", int'(unmask_pend),
             int'(m_sp[0] | m_sp[1] | m_sp[3] | m_sp[4]));
      end
   end

   task automatic step(input bit rq, input int rv, input bit ac, input bit eo);
      req_valid = rq; req_vec = 8'(rv); accept = ac; eoi = eo;
      @(negedge clk);
      req_valid = 0; accept = 0; eoi = 0;
   endtask

   task automatic spc(input bit sv, input int sk, input int svec,
                      input bit cv, input int ck);
      spc_set_valid = sv; spc_set_kind = 3'(sk); spc_set_vec = 8'(svec);
      spc_clr_valid = cv; spc_clr_kind = 3'(ck);
      @(negedge clk);
      spc_set_valid = 0; spc_clr_valid = 0;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 pend_any", int'(pend_any), 0);
      chk("R10 svc_hi", int'(svc_hi), 0);
      chk("R10 spc_pend", int'(spc_pend), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 word/bit mapping across word edges
      step(1, 37, 0, 0);  chk("R1 vec 37", int'(pend_hi), 37);
      step(1, 32, 0, 0);  step(1, 31, 0, 0);
      chk("R1 top stays 37", int'(pend_hi), 37);
      step(1, 255, 0, 0); chk("R1 vec 255", int'(pend_hi), 255);
      // R4 accept moves the top vector
      step(0, 0, 1, 0);
      chk("R4 svc 255", int'(svc_hi), 255);
      chk("R4 pend 37", int'(pend_hi), 37);
      chk("R7 lower class blocked", int'(deliverable), 0);
      // R5 eoi retires
      step(0, 0, 0, 1);
      chk("R5 svc empty", int'(svc_any), 0);
      chk("R7 empty svc delivers", int'(deliverable), 1);
      // R6 request of the accepted vector in the same cycle
      step(1, 37, 1, 0);
      chk("R6 req+accept pend", int'(pend_hi), 37);
      chk("R6 req+accept svc", int'(svc_hi), 37);
      // R6 accept and eoi on the same vector
      step(0, 0, 1, 1);
      chk("R6 acc+eoi svc", int'(svc_hi), 37);
      chk("R6 acc+eoi pend", int'(pend_hi), 32);
      step(0, 0, 1, 0); step(0, 0, 1, 0);
      // R4 accept on empty set
      step(0, 0, 1, 0);
      chk("R4 empty accept svc", int'(svc_hi), 37);
      chk("R3 empty pend hi", int'(pend_hi), 0);
      step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);
      // R5 eoi on empty set
      step(0, 0, 0, 1);
      chk("R5 empty eoi", int'(svc_any), 0);
      // R3 vector 0 is distinct from empty
      step(1, 0, 0, 0);
      chk("R3 vec0 any", int'(pend_any), 1);
      chk("R3 vec0 hi", int'(pend_hi), 0);
      step(0, 0, 1, 0);
      // R7 same class not deliverable, higher class is
      step(1, 5, 0, 0);
      chk("R7 same class", int'(deliverable), 0);
      step(1, 16, 0, 0);
      chk("R7 higher class", int'(deliverable), 1);

      // R9 external alone does not raise the summary
      spc(1, 2, 8'h21, 0, 0);
      chk("R9 ext only", int'(unmask_pend), 0);
      spc(1, 1, 8'h02, 0, 0);
      chk("R9 nmi", int'(unmask_pend), 1);
      // R8 unused code ignored, set beats clear
      spc(1, 6, 8'h55, 0, 0);
      chk("R8 code 6 ignored", int'(spc_pend), 5'b00110);
      spc(1, 1, 8'h44, 1, 1);
      chk("R8 set wins", int'(spc_pend[1]), 1);
      chk("R8 vector stored", int'(spc_vecs[15:8]), 8'h44);
      spc(0, 0, 0, 1, 1);
      chk("R9 nmi cleared", int'(unmask_pend), 0);

      // Random phase with a reset in the middle
      for (int i = 0; i < 3000; i++) begin
         if (i == 1500) begin
            rst_n = 1'b0;
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
         end
         req_valid     = ($urandom_range(2) == 0);
         req_vec       = 8'($urandom_range(255));
         accept        = ($urandom_range(3) == 0);
         eoi           = ($urandom_range(3) == 0);
         spc_set_valid = ($urandom_range(4) == 0);
         spc_set_kind  = 3'($urandom_range(7));
         spc_set_vec   = 8'($urandom_range(255));
         spc_clr_valid = ($urandom_range(4) == 0);
         spc_clr_kind  = 3'($urandom_range(7));
         @(negedge clk);
      end
      req_valid = 0; accept = 0; eoi = 0; spc_set_valid = 0; spc_clr_valid = 0;
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule